// File: doc/BRIEF.md
# Double-Buffered Control Register Bank

This block holds the byte-wide control registers that sit behind a serial control port. Each mapped register exists twice: a staged copy that serial writes land in, and a live copy that the core logic sees. The live copies change only when an update event arrives on the asynchronous update pin. On that event every staged value is copied into the live bank in a single clock cycle, so a group of related settings can be written over several serial transfers and then take effect together.

Serial reads return the live value by default. A select bit in the live bank makes reads return the staged value instead, so software can check pending settings before it commits them. Register 0 also carries the port's own configuration: the bit-order flag and the readback-pin flag. These flags follow the same update rule, so a new bit order takes effect only after an update and then applies to every later port operation. The mapped space is a contiguous window at the bottom of the 13-bit address space. Every location above it reads as zero and ignores writes.

Top module: `dbuf_regbank`

## Requirements
- R1: After reset every staged and live register is 0x00, `lsb_first_o` and `sdo_active_o` are 0 (MSB first, bidirectional), and `rd_data` is 0x00.
- R2: A write with `wr_en` high to a mapped address (below 0x050A) changes only the staged copy. The live copy, as seen on `live_regs` (byte at bits [8*a+7:8*a]) and through live reads, stays unchanged until an update.
- R3: `upd_pin` is synchronized and edge-detected. All live registers take their staged values at the third rising clock edge after the pin rises. One rising edge of the pin causes exactly one transfer, however long the pin stays high.
- R4: A read with `rd_en` high returns its data on `rd_data` at the next rising edge. `rd_data` holds its value while `rd_en` is low.
- R5: When bit 0 of live register 0x0004 is 0, reads return live values. When it is 1, reads return staged values. A write to that bit alters the read source only after an update.
- R6: `lsb_first_o` is bit 6 and `sdo_active_o` is bit 7 of live register 0x0000. Both change only on an update transfer.
- R7: Addresses 0x050A through 0x1FFF are unmapped. Reads of them return 0x00 from either source. Writes to them alter no register, including a mapped register whose address shares their low bits.
- R8: A write that coincides with the transfer cycle lands in the staged copy and is not transferred. It becomes live at the next update.
- R9: Address 0x0509 is the highest mapped register and behaves like any other mapped register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Serial write strobe, one cycle per byte |
| wr_addr | input | 13 | Write byte address |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Serial read strobe, one cycle per byte |
| rd_addr | input | 13 | Read byte address |
| rd_data | output | 8 | Read byte, registered |
| upd_pin | input | 1 | Asynchronous update request, active on rising edge |
| live_regs | output | 10320 | All live registers, byte a at bits [8*a+7:8*a] |
| lsb_first_o | output | 1 | Live bit-order flag for the serial port |
| sdo_active_o | output | 1 | Live readback-pin flag for the serial port |

## Verification
The assertions assume that the strobes and addresses come from the serial port's clock domain and are free of X outside reset. Only `upd_pin` may change with no relation to the clock. The bench drives every input on the falling edge. It holds the update pin at each level for several cycles, so the synchronizer sees every edge. It also times one write to fall on the transfer cycle, counting three rising edges from the pin's rise. Aliasing is exercised with an unmapped address whose low bits equal those of a mapped register.

// File: rtl/dbuf_regbank.sv
module dbuf_regbank #(
  parameter int AW    = 13,
  parameter int DW    = 8,
  parameter int DEPTH = 1290
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_data,
  input  logic               upd_pin,
  output logic [DEPTH*DW-1:0] live_regs,
  output logic               lsb_first_o,
  output logic               sdo_active_o
);
  localparam int IW       = $clog2(DEPTH);
  localparam int CFG_IDX  = 0;
  localparam int SEL_IDX  = 4;
  localparam int LSB_BIT  = 6;
  localparam int SDO_BIT  = 7;

  logic [DW-1:0] shadow_q [DEPTH];
  logic [DW-1:0] live_q   [DEPTH];

  logic upd_s1, upd_s2, upd_d;
  logic upd_pulse;

  logic wr_hit, rd_hit;
  logic [IW-1:0] wr_idx, rd_idx;
  logic rd_from_shadow;

  assign upd_pulse      = upd_s2 & ~upd_d;
  assign wr_hit         = wr_en && (wr_addr < AW'(DEPTH));
  assign rd_hit         = rd_addr < AW'(DEPTH);
  assign wr_idx         = wr_addr[IW-1:0];
  assign rd_idx         = rd_addr[IW-1:0];
  assign rd_from_shadow = live_q[SEL_IDX][0];
  assign lsb_first_o    = live_q[CFG_IDX][LSB_BIT];
  assign sdo_active_o   = live_q[CFG_IDX][SDO_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_s1 <= 1'b0;
      upd_s2 <= 1'b0;
      upd_d  <= 1'b0;
    end else begin
      upd_s1 <= upd_pin;
      upd_s2 <= upd_s1;
      upd_d  <= upd_s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) shadow_q[i] <= '0;
    end else if (wr_hit) begin
      shadow_q[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) live_q[i] <= '0;
    end else if (upd_pulse) begin
      for (int i = 0; i < DEPTH; i++) live_q[i] <= shadow_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= !rd_hit ? '0 : (rd_from_shadow ? shadow_q[rd_idx] : live_q[rd_idx]);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign live_regs[g*DW +: DW] = live_q[g];
  end
endmodule

// File: rtl/dbuf_regbank_chk.sv
module dbuf_regbank_chk #(
  parameter int AW    = 13,
  parameter int DW    = 8,
  parameter int DEPTH = 1290
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_en,
  input logic [AW-1:0]      rd_addr,
  input logic [DW-1:0]      rd_data,
  input logic               upd_pulse,
  input logic [DEPTH*DW-1:0] live_regs,
  input logic               lsb_first_o,
  input logic               sdo_active_o
);
  // R2
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_pulse |=> $stable(live_regs));

  // R3
  single_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |=> !upd_pulse);

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_pulse |=> $stable({lsb_first_o, sdo_active_o}));

  // R7
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr >= AW'(DEPTH)) |=> rd_data == '0);
endmodule

bind dbuf_regbank dbuf_regbank_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .upd_pulse(upd_pulse), .live_regs(live_regs),
  .lsb_first_o(lsb_first_o), .sdo_active_o(sdo_active_o)
);

// File: tb/tb_dbuf_regbank.sv
module tb_dbuf_regbank;
  localparam int DEPTH = 1290;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, upd_pin = 0;
  logic [12:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [DEPTH*8-1:0] live_regs;
  logic lsb_first_o, sdo_active_o;

  int n_vec = 0, n_bad = 0;

  dbuf_regbank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .upd_pin(upd_pin),
    .live_regs(live_regs), .lsb_first_o(lsb_first_o), .sdo_active_o(sdo_active_o)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic update();
    @(negedge clk); upd_pin = 1;
    repeat (4) @(negedge clk);
    upd_pin = 0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] live(input int a);
    return live_regs[a*8 +: 8];
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    check("R1 live bank zero", {31'd0, live_regs == '0}, 32'd1);
    check("R1 lsb_first", lsb_first_o, 0);
    check("R1 sdo_active", sdo_active_o, 0);
    check("R1 rd_data", rd_data, 0);
    rd(13'h0509, d); check("R1 read 0x509", d, 0);
  endtask

  task automatic t_staged_only();
    logic [7:0] d;
    wr(13'h0010, 8'hA5);
    repeat (3) @(negedge clk);
    check("R2 live unchanged", live(16), 0);
    rd(13'h0010, d); check("R2 live read", d, 0);
  endtask

  task automatic t_update_timing();
    logic [7:0] d;
    @(negedge clk); upd_pin = 1;
    @(negedge clk); check("R3 edge1", live(16), 0);
    @(negedge clk); check("R3 edge2", live(16), 0);
    @(negedge clk); check("R3 edge3", live(16), 8'hA5);
    wr(13'h0010, 8'h3C);
    repeat (5) @(negedge clk);
    check("R3 one transfer per edge", live(16), 8'hA5);
    upd_pin = 0;
    repeat (3) @(negedge clk);
    rd(13'h0010, d); check("R4 read data", d, 8'hA5);
    wr(13'h0011, 8'h01);
    repeat (3) @(negedge clk);
    check("R4 rd_data held", rd_data, 8'hA5);
  endtask

  task automatic t_select();
    logic [7:0] d;
    wr(13'h0004, 8'h01);
    rd(13'h0010, d); check("R5 select pending", d, 8'hA5);
    update();
    wr(13'h0010, 8'h77);
    rd(13'h0010, d); check("R5 staged read", d, 8'h77);
    wr(13'h0004, 8'h00);
    rd(13'h0004, d); check("R5 select still staged", d, 8'h00);
    update();
    wr(13'h0010, 8'h11);
    rd(13'h0010, d); check("R5 back to live", d, 8'h77);
  endtask

  task automatic t_cfg();
    wr(13'h0000, 8'hC0);
    repeat (4) @(negedge clk);
    check("R6 lsb before update", lsb_first_o, 0);
    check("R6 sdo before update", sdo_active_o, 0);
    update();
    check("R6 lsb after update", lsb_first_o, 1);
    check("R6 sdo after update", sdo_active_o, 1);
    wr(13'h0000, 8'h40);
    update();
    check("R6 lsb kept", lsb_first_o, 1);
    check("R6 sdo cleared", sdo_active_o, 0);
    wr(13'h0000, 8'h00);
    update();
    check("R6 lsb cleared", lsb_first_o, 0);
  endtask

  task automatic t_coincide();
    logic [7:0] d;
    @(negedge clk); upd_pin = 1;
    @(negedge clk);
    @(negedge clk); wr_en = 1; wr_addr = 13'h0020; wr_data = 8'h99;
    @(negedge clk); wr_en = 0;
    check("R8 not transferred", live(32), 0);
    check("R8 other reg transferred", live(16), 8'h11);
    repeat (3) @(negedge clk); upd_pin = 0;
    repeat (3) @(negedge clk);
    rd(13'h0020, d); check("R8 live read", d, 0);
    update();
    check("R8 next update", live(32), 8'h99);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    logic [DEPTH*8-1:0] snap;
    snap = live_regs;
    wr(13'h050A, 8'hFF);
    wr(13'h1FFF, 8'hEE);
    wr(13'h1010, 8'hEE);
    update();
    check("R7 live bank untouched", {31'd0, live_regs == snap}, 32'd1);
    rd(13'h050A, d); check("R7 live read 0x50A", d, 0);
    rd(13'h1FFF, d); check("R7 live read 0x1FFF", d, 0);
    wr(13'h0004, 8'h01);
    update();
    rd(13'h050A, d); check("R7 staged read 0x50A", d, 0);
    rd(13'h1010, d); check("R7 staged read 0x1010", d, 0);
    rd(13'h0010, d); check("R7 alias untouched", d, 8'h11);
    wr(13'h0004, 8'h00);
    update();
  endtask

  task automatic t_top();
    logic [7:0] d;
    wr(13'h0509, 8'h42);
    update();
    rd(13'h0509, d); check("R9 top read", d, 8'h42);
    check("R9 top live byte", live(DEPTH-1), 8'h42);
  endtask

  initial begin
    #200000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_staged_only();
    t_update_timing();
    t_select();
    t_cfg();
    t_coincide();
    t_unmapped();
    t_top();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule